// File: doc/BRIEF.md
# Three-Stage Decimating Filter Chain

The block takes one signed oversampled word on every clock and reduces the rate in three steps. The first step is a third-order sinc (CIC) decimator whose ratio R is chosen by a static two-bit code. Its integrators run at the full clock rate and wrap modulo their width. Its combs run once every R clocks. Two half-band FIR stages follow, and each one halves the rate again, so the chain decimates by 8, 16 or 32. Each FIR stage uses the symmetric integer kernel (-1, 0, 9, 16, 9, 0, -1)/32, and it computes only every second output.

The last stage rounds the wide result to 24-bit two's complement and saturates it. Each word is flagged by a one-cycle strobe. A tracker counts input clocks after reset and raises `settled` once the whole filter history is full, at 24·R clocks (3R for the sinc span, 7R and 14R for the two half-band spans). The rate code may change only while reset is held.

The tracker has two named states. TRK_FILL follows reset and moves to TRK_SETTLED when its counter reaches 24·R−1. TRK_SETTLED holds until reset. Each half-band stage alternates between HB_WAIT_EVEN and HB_WAIT_ODD on every accepted input. The move from HB_WAIT_ODD back to HB_WAIT_EVEN schedules a computation.

Top module: `decim_chain`

## Requirements
- R1: Rate codes 0, 1 and 2 select sinc ratios 2, 4 and 8. Successive `result_valid` pulses are then exactly 8, 16 and 32 clocks apart.
- R2: `result_valid` is high for exactly one clock per output word.
- R3: With a constant input x held long enough to settle, `result` equals x·2^(OUT_W−IN_W) (x·256 at the defaults) as a two's-complement word.
- R4: Each half-band stage emits one word per two input words, so the final rate is one quarter of the sinc stage's rate.
- R5: The wide result is rounded and then clamped, never wrapped. Anything above 0x7FFFFF gives 0x7FFFFF, and anything below 0x800000 gives 0x800000. A held input of 32767 gives 0x7FFF00, and a held input of −32768 gives 0x800000.
- R6: `settled` is low in reset. It rises on exactly the 24·R-th rising edge after reset is released, and it stays high until the next reset.
- R7: While `rst_n` is low, `result` is 0 and `result_valid` is 0.
- R8: Rate code 3 behaves as ratio 8 (32-clock output spacing, settling at 192 clocks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Sinc ratio code: 0→2, 1→4, 2 or 3→8; static outside reset |
| sample_in | input | IN_W | Signed oversampled input word |
| result | output | OUT_W | Rounded, saturated two's-complement output word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |
| settled | output | 1 | High once the full filter history has been filled |

## Verification
Constant inputs of both signs and at both full-scale ends are applied at every rate code. The DC gain shows whether each stage's normalisation and the sinc gain compensation are right, and the full-scale values show whether the modular integrators wrap correctly. A large step from negative to positive full scale, and back, drives the half-band overshoot beyond 24 bits, which separates clamping from wrapping. The spacing of the strobes at each code, and the exact cycle at which `settled` rises, separate the three ratios from each other and from the code that falls back to ratio 8.

// File: rtl/decim_pkg.sv
package decim_pkg;

    localparam int CIC_ORDER   = 3;
    localparam int LOG2R_MAX   = 3;
    localparam int SETTLE_MULT = 24;

    typedef enum logic {
        TRK_FILL    = 1'b0,
        TRK_SETTLED = 1'b1
    } trk_state_t;

    typedef enum logic {
        HB_WAIT_EVEN = 1'b0,
        HB_WAIT_ODD  = 1'b1
    } hb_phase_t;

    function automatic logic [1:0] code_to_log2(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import decim_pkg::*;
#(
    parameter  int IN_W   = 16,
    parameter  int L2_MAX = LOG2R_MAX,
    localparam int ACC_W  = IN_W + CIC_ORDER * L2_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              log2r,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [ACC_W-1:0] dout,
    output logic                    dvalid
);

    logic signed [ACC_W-1:0] integ [CIC_ORDER];
    logic signed [ACC_W-1:0] dly   [CIC_ORDER];
    logic signed [ACC_W-1:0] diff  [CIC_ORDER+1];
    logic [L2_MAX-1:0]       phase;
    logic [L2_MAX-1:0]       last_phase;
    logic [3:0]              up_sh;
    logic                    tick;

    assign last_phase = L2_MAX'((1 << log2r) - 1);
    assign tick       = (phase == last_phase);
    assign up_sh      = 4'(CIC_ORDER * (L2_MAX - int'(log2r)));

    // integrators: modular, pipelined
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < CIC_ORDER; k++) integ[k] <= '0;
        end else begin
            integ[0] <= integ[0] + ACC_W'(din);
            for (int k = 1; k < CIC_ORDER; k++) integ[k] <= integ[k] + integ[k-1];
        end
    end

    always_comb begin
        diff[0] = integ[CIC_ORDER-1];
        for (int k = 0; k < CIC_ORDER; k++) diff[k+1] = diff[k] - dly[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < CIC_ORDER; k++) dly[k] <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= tick;
            if (tick) begin
                for (int k = 0; k < CIC_ORDER; k++) dly[k] <= diff[k];
                dout <= diff[CIC_ORDER] <<< up_sh;
            end
        end
    end

    AST_CIC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid) else $error("sinc strobe longer than one cycle"); // R1

endmodule

// File: rtl/hb_dec2.sv
module hb_dec2
    import decim_pkg::*;
#(
    parameter  int W  = 25,
    localparam int OW = W + 1,
    localparam int AW = W + 6,
    localparam int NT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  din,
    input  logic                 din_valid,
    output logic signed [OW-1:0] dout,
    output logic                 dvalid
);

    localparam logic signed [AW-1:0] K_CTR  = AW'(16);
    localparam logic signed [AW-1:0] K_NEAR = AW'(9);
    localparam logic signed [AW-1:0] K_HALF = AW'(16);

    logic signed [W-1:0]  tap [NT];
    hb_phase_t            ph_q, ph_d;
    logic                 fire;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] rnd;

    // phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= HB_WAIT_EVEN;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        if (din_valid) begin
            unique case (ph_q)
                HB_WAIT_EVEN: ph_d = HB_WAIT_ODD;
                HB_WAIT_ODD:  ph_d = HB_WAIT_EVEN;
            endcase
        end
    end

    // symmetric kernel, zero taps skipped
    always_comb begin
        acc = K_CTR * AW'(tap[3])
            + K_NEAR * (AW'(tap[2]) + AW'(tap[4]))
            - (AW'(tap[0]) + AW'(tap[6]));
        rnd = (acc + K_HALF) >>> 5;
    end

    // outputs and delay line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NT; k++) tap[k] <= '0;
            fire   <= 1'b0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            fire   <= din_valid && (ph_q == HB_WAIT_ODD);
            dvalid <= fire;
            if (fire) dout <= OW'(rnd);
            if (din_valid) begin
                tap[0] <= din;
                for (int k = 1; k < NT; k++) tap[k] <= tap[k-1];
            end
        end
    end

    AST_HB_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> $past(din_valid, 2)) else $error("half-band output without input"); // R4
    AST_HB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid) else $error("half-band strobe longer than one cycle"); // R2

endmodule

// File: rtl/round_sat.sv
module round_sat #(
    parameter int IN_W  = 27,
    parameter int OUT_W = 24,
    parameter int DROP  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  din,
    input  logic                    din_valid,
    output logic signed [OUT_W-1:0] dout,
    output logic                    dvalid
);

    localparam logic signed [IN_W-1:0] POS_LIM =
        {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] NEG_LIM =
        {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [OUT_W-1:0] POS_OUT = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] NEG_OUT = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [IN_W-1:0]  rounded;
    logic signed [OUT_W-1:0] clamped;

    generate
        if (DROP > 0) begin : g_round
            assign rounded = (din + (IN_W'(1) <<< (DROP - 1))) >>> DROP;
        end else begin : g_pass
            assign rounded = din;
        end
    endgenerate

    always_comb begin
        if (rounded > POS_LIM)      clamped = POS_OUT;
        else if (rounded < NEG_LIM) clamped = NEG_OUT;
        else                        clamped = OUT_W'(rounded);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= din_valid;
            if (din_valid) dout <= clamped;
        end
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && (rounded > POS_LIM)) |=> (dout == POS_OUT)) else $error("no clamp high"); // R5
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && (rounded < NEG_LIM)) |=> (dout == NEG_OUT)) else $error("no clamp low"); // R5

endmodule

// File: rtl/settle_track.sv
module settle_track
    import decim_pkg::*;
#(
    parameter  int MULT   = SETTLE_MULT,
    parameter  int L2_MAX = LOG2R_MAX,
    localparam int CNT_W  = $clog2((MULT << L2_MAX) + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] log2r,
    output logic       settled
);

    trk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(MULT << log2r);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRK_FILL) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_FILL:    if (cnt_q == limit - 1'b1) state_d = TRK_SETTLED;
            TRK_SETTLED: state_d = TRK_SETTLED;
        endcase
    end

    always_comb settled = (state_q == TRK_SETTLED);

    AST_SETTLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        settled |=> settled) else $error("settled dropped"); // R6

endmodule

// File: rtl/decim_chain.sv
module decim_chain
    import decim_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic [IN_W-1:0]  sample_in,
    output logic [OUT_W-1:0] result,
    output logic             result_valid,
    output logic             settled
);

    localparam int CIC_W = IN_W + CIC_ORDER * LOG2R_MAX;
    localparam int HB1_W = CIC_W + 1;
    localparam int HB2_W = HB1_W + 1;
    localparam int DROP  = CIC_W - OUT_W;

    logic [1:0]               log2r;
    logic signed [CIC_W-1:0]  cic_q;
    logic                     cic_v;
    logic signed [HB1_W-1:0]  hb1_q;
    logic                     hb1_v;
    logic signed [HB2_W-1:0]  hb2_q;
    logic                     hb2_v;
    logic signed [OUT_W-1:0]  out_q;

    assign log2r = code_to_log2(rate_sel);

    sinc3_decim #(.IN_W(IN_W), .L2_MAX(LOG2R_MAX)) u_sinc (
        .clk(clk), .rst_n(rst_n), .log2r(log2r), .din($signed(sample_in)),
        .dout(cic_q), .dvalid(cic_v)
    );

    hb_dec2 #(.W(CIC_W)) u_hb1 (
        .clk(clk), .rst_n(rst_n), .din(cic_q), .din_valid(cic_v),
        .dout(hb1_q), .dvalid(hb1_v)
    );

    hb_dec2 #(.W(HB1_W)) u_hb2 (
        .clk(clk), .rst_n(rst_n), .din(hb1_q), .din_valid(hb1_v),
        .dout(hb2_q), .dvalid(hb2_v)
    );

    round_sat #(.IN_W(HB2_W), .OUT_W(OUT_W), .DROP(DROP)) u_out (
        .clk(clk), .rst_n(rst_n), .din(hb2_q), .din_valid(hb2_v),
        .dout(out_q), .dvalid(result_valid)
    );

    settle_track #(.MULT(SETTLE_MULT), .L2_MAX(LOG2R_MAX)) u_trk (
        .clk(clk), .rst_n(rst_n), .log2r(log2r), .settled(settled)
    );

    assign result = out_q;

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid) else $error("result strobe too long"); // R2

endmodule

// File: tb/test_decim_chain.sv
`timescale 1ns/1ps
module test_decim_chain;

    localparam int IN_W     = 16;
    localparam int OUT_W    = 24;
    localparam int SCALE_SH = OUT_W - IN_W;
    localparam int MAX_OUT  = (1 <<< (OUT_W - 1)) - 1;
    localparam int MIN_OUT  = -(1 <<< (OUT_W - 1));

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       rate_sel;
    logic [IN_W-1:0]  sample_in;
    logic [OUT_W-1:0] result;
    logic             result_valid;
    logic             settled;

    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string exp_tag = "R3";
    int    cur_d = 8;
    int    gap = 0;
    bit    have_prev = 0;
    bit    prev_v = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    decim_chain #(.IN_W(IN_W), .OUT_W(OUT_W)) i_decim_chain (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .sample_in(sample_in),
        .result(result), .result_valid(result_valid), .settled(settled)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: spacing, pulse width, scoreboard pop
    always @(negedge clk) begin
        int e;
        if (!rst_n) begin
            have_prev = 0;
            gap = 0;
            prev_v = 0;
        end else begin
            gap = gap + 1;
            if (result_valid) begin
                check(!prev_v, "R2 one-cycle strobe", prev_v, 0);
                if (have_prev) check(gap == cur_d, "R1 R4 R8 output spacing", gap, cur_d);
                have_prev = 1;
                gap = 0;
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check(int'($signed(result)) == e, exp_tag, int'($signed(result)), e);
                end
            end
            prev_v = result_valid;
        end
    end

    task automatic wait_outputs(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!result_valid) @(negedge clk);
        end
    endtask

    task automatic start_rate(input logic [1:0] sel, input int r);
        @(negedge clk);
        rst_n = 1'b0;
        rate_sel = sel;
        sample_in = '0;
        cur_d = 4 * r;
        repeat (3) @(negedge clk);
        check(result == '0 && !result_valid, "R7 outputs cleared in reset", result, 0);
        check(!settled, "R6 settled low in reset", settled, 0);
        rst_n = 1'b1;
        repeat (24 * r - 1) @(posedge clk);
        @(negedge clk);
        check(!settled, "R6 settled still low one edge early", settled, 0);
        @(posedge clk);
        @(negedge clk);
        check(settled, "R6 settled high at 24R edges", settled, 1);
    endtask

    // driver: hold a level, then queue the expected settled words
    task automatic push_dc(input int x, input int n, input string tag);
        sample_in = IN_W'(x);
        wait_outputs(40);
        @(posedge clk);
        exp_tag = tag;
        for (int i = 0; i < n; i++) exp_q.push_back(x * (1 <<< SCALE_SH));
        while (exp_q.size() > 0) @(negedge clk);
        check(settled, "R6 settled stays high", settled, 1);
    endtask

    task automatic step_probe(input int to, input bit up);
        bit saw = 0;
        bit wrap = 0;
        bit crossed = 0;
        int v;
        sample_in = IN_W'(to);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            while (!result_valid) @(negedge clk);
            v = int'($signed(result));
            if (up) begin
                if (crossed && v < 0) wrap = 1;
                if (v > 0) crossed = 1;
                if (v == MAX_OUT) saw = 1;
            end else begin
                if (crossed && v > 0) wrap = 1;
                if (v < 0) crossed = 1;
                if (v == MIN_OUT) saw = 1;
            end
        end
        check(saw, up ? "R5 overshoot clamps to 0x7FFFFF" : "R5 undershoot clamps to 0x800000", saw, 1);
        check(!wrap, "R5 no wrap on step", wrap, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rate_sel = 2'd0;
        sample_in = '0;

        start_rate(2'd0, 2);
        push_dc(1000, 4, "R3 dc +1000 ratio 2");
        push_dc(-12345, 4, "R3 dc -12345 ratio 2");
        push_dc(32767, 3, "R5 full-scale positive 0x7FFF00");
        push_dc(-32768, 3, "R5 full-scale negative 0x800000");
        step_probe(32767, 1'b1);
        step_probe(-32768, 1'b0);

        start_rate(2'd1, 4);
        push_dc(-777, 3, "R3 dc -777 ratio 4");
        push_dc(20000, 3, "R3 dc +20000 ratio 4");

        start_rate(2'd2, 8);
        push_dc(4321, 3, "R3 dc +4321 ratio 8");
        push_dc(-32768, 3, "R3 wrap-safe full-scale ratio 8");

        start_rate(2'd3, 8);
        push_dc(-30000, 3, "R8 code 3 dc -30000");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule